// File: doc/BRIEF.md
# Line Blanking Injector with Position Flags

This block sits in a video datapath between a per-channel lookup stage and the arithmetic that follows. It carries four parallel sample channels. While the active-low blanking input is low, every channel's output is replaced by a programmable blanking word for that channel. Outside blanking the samples pass through unchanged. The output is registered, so both paths have the same one-cycle latency.

A position counter shows how far the current line has advanced. It is held at zero while blanking is low. After blanking ends it counts up by one per clock and stops at its all-ones value. Each of two flags has its own programmable mark. A flag rises once the counter has reached that flag's mark, and it stays high until it is cleared. Two things clear the flags. Blanking clears them during normal running. A synchronous active-low initialise input clears them at start-up, one clock after it is sampled low. The mark values are taken from their inputs only during blanking or an initialise. Reprogramming them in the middle of a line therefore leaves that line alone.

Top module: `blank_inject_top`

## Requirements
- R1: With the blanking input sampled high at a clock edge, each channel's output after that edge equals the data input sampled at that edge. Channel A occupies bits [DW-1:0], B the next DW bits, then C, then D.
- R2: With the blanking input sampled low at a clock edge, each channel's output after that edge equals that channel's blanking word sampled at that edge. The blanking words use the same channel layout as the data.
- R3: The position counter is 0 after any edge at which the blanking input is sampled low. After an edge at which it is sampled high, with no initialise clear taking effect, the counter is one more than its value before that edge.
- R4: The position counter stops at 2^CW-1 and holds that value while blanking stays high.
- R5: A flag is set at an edge where the blanking input is high and the counter value before the edge equals that flag's captured mark. Once set, the flag stays high until it is cleared.
- R6: An edge at which the blanking input is sampled low clears both flags, and this clear takes priority over a set.
- R7: If the initialise input is sampled low at edge k, both flags and the counter are 0 after edge k+1. The flags are not cleared by edge k itself.
- R8: Each mark is captured from its input only at an edge where the blanking input is low or an initialise clear takes effect. Mark input changes at other edges do not affect the flags.
- R9: While the asynchronous reset is low, the data outputs, the counter and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_n | input | 1 | Synchronous active-low initialise; clears flags and counter one cycle later |
| blank_n | input | 1 | Active-low blanking |
| data_in | input | NCH*DW | Channel samples, A in the low bits |
| blank_word_in | input | NCH*DW | Per-channel blanking words, same layout |
| mark0_in | input | CW | Count mark for flag 0 |
| mark1_in | input | CW | Count mark for flag 1 |
| data_out | output | NCH*DW | Registered channel output |
| pos_cnt | output | CW | Line position counter |
| flag0 | output | 1 | Flag 0 |
| flag1 | output | 1 | Flag 1 |

## Verification
The bench targets the exact cycle at which each flag rises, one edge after the counter shows the mark. An off-by-one compare would raise a flag a cycle early or late. It checks that a mark rewritten mid-line has no effect, which a design without captured marks would miss by firing on the new value. It checks that initialise clears the flags one edge late and not at once, and that the counter stops at all ones instead of wrapping to zero. A mark of zero is also exercised, because the first active edge has to raise the flag even though the counter has just left blanking.

// File: rtl/blank_pkg.sv
package blank_pkg;
  // Action applied to a position flag on the next edge.
  typedef enum logic [1:0] {
    FOP_HOLD = 2'd0,
    FOP_SET  = 2'd1,
    FOP_CLR  = 2'd2
  } flag_op_e;

  localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/blank_rst_sync.sv
module blank_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/blank_mux.sv
module blank_mux #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank_n,
  input  logic [NCH*DW-1:0] data_in,
  input  logic [NCH*DW-1:0] word_in,
  output logic [NCH*DW-1:0] data_out
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] out_d;
    logic [DW-1:0] out_q;

    always_comb begin
      if (!blank_n) out_d = word_in[ch*DW +: DW];
      else          out_d = data_in[ch*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= out_d;
    end

    assign data_out[ch*DW +: DW] = out_q;
  end
endmodule

// File: rtl/blank_line_counter.sv
module blank_line_counter #(
  parameter int unsigned CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || (cnt_q != CNT_MAX);
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/blank_mark_flag.sv
module blank_mark_flag
  import blank_pkg::*;
#(
  parameter int unsigned CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clr,
  input  logic [CW-1:0] mark_in,
  input  logic [CW-1:0] cnt,
  output logic          flag
);
  logic [CW-1:0] mark_q;
  logic          flag_q;
  logic          flag_d;
  flag_op_e      op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mark_q <= '0;
    else if (load) mark_q <= mark_in;
  end

  always_comb begin
    if (clr)                op = FOP_CLR;
    else if (cnt == mark_q) op = FOP_SET;
    else                    op = FOP_HOLD;
    case (op)
      FOP_CLR: flag_d = 1'b0;
      FOP_SET: flag_d = 1'b1;
      default: flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/blank_inject_top.sv
module blank_inject_top
  import blank_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 13,
  parameter int unsigned CW  = 20
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              init_n,
  input  logic              blank_n,
  input  logic [NCH*DW-1:0] data_in,
  input  logic [NCH*DW-1:0] blank_word_in,
  input  logic [CW-1:0]     mark0_in,
  input  logic [CW-1:0]     mark1_in,
  output logic [NCH*DW-1:0] data_out,
  output logic [CW-1:0]     pos_cnt,
  output logic              flag0,
  output logic              flag1
);
  logic                 rst_n;
  logic                 init_q;
  logic                 clr_all;
  logic [CW-1:0]        mark_vec [NUM_FLAGS];
  logic [NUM_FLAGS-1:0] flg;

  blank_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  // Initialise takes effect one edge after it is sampled low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b0;
    else        init_q <= ~init_n;
  end

  assign clr_all = init_q | ~blank_n;

  blank_mux #(.NCH(NCH), .DW(DW)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .blank_n  (blank_n),
    .data_in  (data_in),
    .word_in  (blank_word_in),
    .data_out (data_out)
  );

  blank_line_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .cnt   (pos_cnt)
  );

  assign mark_vec[0] = mark0_in;
  assign mark_vec[1] = mark1_in;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    blank_mark_flag #(.CW(CW)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (clr_all),
      .clr     (clr_all),
      .mark_in (mark_vec[f]),
      .cnt     (pos_cnt),
      .flag    (flg[f])
    );
  end

  assign flag0 = flg[0];
  assign flag1 = flg[1];
endmodule

// File: rtl/blank_inject_chk.sv
module blank_inject_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 13,
  parameter int unsigned CW  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_n,
  input logic              init_q,
  input logic              blank_n,
  input logic [NCH*DW-1:0] data_in,
  input logic [NCH*DW-1:0] blank_word_in,
  input logic [NCH*DW-1:0] data_out,
  input logic [CW-1:0]     pos_cnt,
  input logic              flag0,
  input logic              flag1
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CONE = CW'(1);

  // R1
  pass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_n |=> data_out == $past(data_in));

  // R2
  blank_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> data_out == $past(blank_word_in));

  // R3
  cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> pos_cnt == '0);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !init_q && pos_cnt != CMAX) |=> pos_cnt == $past(pos_cnt) + CONE);

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !init_q && pos_cnt == CMAX) |=> pos_cnt == CMAX);

  // R6
  blank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (!flag0 && !flag1));

  // R7
  init_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> ##2 (!flag0 && !flag1 && pos_cnt == '0));

  // R5
  flag0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && blank_n && !init_q) |=> flag0);

  // R5
  flag1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1 && blank_n && !init_q) |=> flag1);
endmodule

bind blank_inject_top blank_inject_chk #(.NCH(NCH), .DW(DW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .init_n        (init_n),
  .init_q        (init_q),
  .blank_n       (blank_n),
  .data_in       (data_in),
  .blank_word_in (blank_word_in),
  .data_out      (data_out),
  .pos_cnt       (pos_cnt),
  .flag0         (flag0),
  .flag1         (flag1)
);

// File: tb/blank_inject_top_test.sv
module blank_inject_top_test;
  localparam int unsigned NCH = 4;
  localparam int unsigned DW  = 13;
  localparam int unsigned CW  = 8;

  logic              clk;
  logic              arst_n;
  logic              init_n;
  logic              blank_n;
  logic [NCH*DW-1:0] data_in;
  logic [NCH*DW-1:0] blank_word_in;
  logic [CW-1:0]     mark0_in;
  logic [CW-1:0]     mark1_in;
  logic [NCH*DW-1:0] data_out;
  logic [CW-1:0]     pos_cnt;
  logic              flag0;
  logic              flag1;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  blank_inject_top #(.NCH(NCH), .DW(DW), .CW(CW)) uut (
    .clk (clk), .arst_n (arst_n), .init_n (init_n), .blank_n (blank_n),
    .data_in (data_in), .blank_word_in (blank_word_in),
    .mark0_in (mark0_in), .mark1_in (mark1_in),
    .data_out (data_out), .pos_cnt (pos_cnt), .flag0 (flag0), .flag1 (flag1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [NCH*DW-1:0] pack4(input logic [DW-1:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    arst_n = 1'b0; init_n = 1'b1; blank_n = 1'b1;
    data_in = pack4(13'h1abc, 13'h0123, 13'h1fff, 13'h0555);
    blank_word_in = '0; mark0_in = '0; mark1_in = '0;
    repeat (3) tick();
    check("R9 data", 64'(data_out), 64'd0);
    check("R9 cnt", 64'(pos_cnt), 64'd0);
    check("R9 flags", 64'({flag1, flag0}), 64'd0);
    arst_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic t_pass();
    logic [NCH*DW-1:0] pats [3];
    pats[0] = pack4(13'h0001, 13'h0002, 13'h0003, 13'h0004);
    pats[1] = '1;
    pats[2] = pack4(13'h0aaa, 13'h1555, 13'h0aaa, 13'h1555);
    blank_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      data_in = pats[i];
      blank_word_in = ~pats[i];
      tick();
      check("R1 pass", 64'(data_out), 64'(pats[i]));
    end
  endtask

  task automatic t_blank();
    logic [NCH*DW-1:0] w;
    w = pack4(13'h0040, 13'h0200, 13'h0201, 13'h1000);
    data_in = pack4(13'h1111, 13'h0222, 13'h0333, 13'h0444);
    blank_word_in = w;
    blank_n = 1'b0;
    tick();
    check("R2 blank words", 64'(data_out), 64'(w));
    blank_word_in = pack4(13'h0007, 13'h0008, 13'h0009, 13'h000a);
    tick();
    check("R2 word update", 64'(data_out), 64'(pack4(13'h0007, 13'h0008, 13'h0009, 13'h000a)));
    blank_n = 1'b1;
    tick();
    check("R1 after blank", 64'(data_out), 64'(data_in));
  endtask

  task automatic t_line_flags();
    blank_n = 1'b0; mark0_in = 8'd3; mark1_in = 8'd5;
    tick();
    check("R3 zero in blank", 64'(pos_cnt), 64'd0);
    check("R6 flags in blank", 64'({flag1, flag0}), 64'd0);
    blank_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      check("R3 count", 64'(pos_cnt), 64'(k));
      check("R5 flag0", 64'(flag0), 64'(k >= 4));
      check("R5 flag1", 64'(flag1), 64'(k >= 6));
    end
  endtask

  task automatic t_blank_clear();
    blank_n = 1'b0;
    tick();
    check("R6 blank clears", 64'({flag1, flag0}), 64'd0);
    check("R3 cleared", 64'(pos_cnt), 64'd0);
  endtask

  task automatic t_mark_ignored();
    blank_n = 1'b0; mark0_in = 8'd4; mark1_in = 8'd200;
    tick();
    blank_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      if (k == 2) begin
        mark0_in = 8'd20;
        mark1_in = 8'd6;
      end
      check("R8 old mark0 used", 64'(flag0), 64'(k >= 5));
      check("R8 new mark1 ignored", 64'(flag1), 64'd0);
    end
  endtask

  task automatic t_init();
    init_n = 1'b0;
    tick();
    init_n = 1'b1;
    check("R7 not yet cleared", 64'(flag0), 64'd1);
    check("R7 cnt runs", 64'(pos_cnt), 64'd9);
    tick();
    check("R7 flags cleared", 64'({flag1, flag0}), 64'd0);
    check("R7 cnt cleared", 64'(pos_cnt), 64'd0);
  endtask

  task automatic t_mark_zero();
    blank_n = 1'b0; mark0_in = 8'd0; mark1_in = 8'd2;
    tick();
    blank_n = 1'b1;
    tick();
    check("R5 mark zero", 64'(flag0), 64'd1);
    check("R5 flag1 not yet", 64'(flag1), 64'd0);
    check("R3 first step", 64'(pos_cnt), 64'd1);
  endtask

  task automatic t_saturate();
    blank_n = 1'b0; mark0_in = 8'd100; mark1_in = 8'd255;
    tick();
    blank_n = 1'b1;
    for (int k = 1; k <= 300; k++) begin
      tick();
      if (k == 255) begin
        check("R4 reach max", 64'(pos_cnt), 64'd255);
        check("R5 flag1 before", 64'(flag1), 64'd0);
      end
      if (k == 300) begin
        check("R4 hold max", 64'(pos_cnt), 64'd255);
        check("R5 flag1 at max", 64'(flag1), 64'd1);
        check("R5 flag0 sticky", 64'(flag0), 64'd1);
      end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass();
    t_blank();
    t_line_flags();
    t_blank_clear();
    t_mark_ignored();
    t_init();
    t_mark_zero();
    t_saturate();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule